// File: doc/BRIEF.md
# Stereo Sample Transmit Queue

This block is a small queue between a register bus, written by a processor or a DMA engine, and an audio serializer that sends one left/right pair per frame. Each entry holds a 16-bit left and a 16-bit right sample. A pair is written in one of two ways. A single 32-bit access at the base offset carries both samples. Two 16-bit accesses can also be used: the left sample goes to the base offset and is staged, and the right sample at the next half-word offset completes the pair. Byte accesses and the reserved size code are ignored.

The serializer reads the oldest pair from the head outputs and pops it. Playback begins only once the queue is completely full. After the queue runs dry, the read side goes idle again and does not pop until all entries have been rewritten. Every accepted pop frees one slot. That event sets a DMA request, which stays set until it is acknowledged, and it also pulses an interrupt when the interrupt is enabled. DMA can therefore run with the interrupt masked.

Top module: `stereo_tx_fifo`

## Requirements
- R1: `level` reports the number of stored pairs, from 0 to 4 (DEPTH). `full` is 1 exactly when `level` equals 4.
- R2: A write with `wr_size`=2'b10 and `wr_hi`=0 stores one pair in a single cycle: left from `wr_data[15:0]`, right from `wr_data[31:16]`.
- R3: A write with `wr_size`=2'b01 and `wr_hi`=0 stages `wr_data[15:0]` as a left sample and does not change `level`. A following write with `wr_size`=2'b01 and `wr_hi`=1 stores the pair, taking the right sample from `wr_data[15:0]`. If no left sample is staged, a right half-word write is ignored.
- R4: Writes with `wr_size`=2'b00 (byte) or 2'b11 (reserved) change neither the stored pairs nor the staged sample. A 32-bit write with `wr_hi`=1 is also ignored.
- R5: A pair written while `full`=1, with no pop accepted in the same cycle, replaces the most recently written pair. `level` stays at 4.
- R6: `empty` is 1 exactly when `level` is 0. It is set when the last pair is popped and clears on the cycle after a pair is written.
- R7: After reset, and after every pop that leaves the queue empty, `frame_valid` stays 0 and `pop` is ignored until `level` reaches 4.
- R8: Each accepted pop (`pop` with `frame_valid`=1) sets `dma_req` on the next cycle. `dma_req` stays set until a `dma_ack` strobe arrives, and a new pop in the same cycle as the strobe wins.
- R9: `irq` pulses for one cycle, the cycle after an accepted pop, if `irq_en` was 1 at that pop. It stays 0 otherwise.
- R10: A second left half-word write before the right half-word write replaces the staged left sample.
- R11: After reset, `level`=0, `empty`=1, `full`=0, `frame_valid`=0, `irq`=0, `dma_req`=0, and no left sample is staged.
- R12: Pairs leave in write order. `head_left`/`head_right` show the oldest pair whenever `frame_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_hi | input | 1 | 0 = base offset, 1 = upper half-word offset |
| wr_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| wr_data | input | 32 | Write data |
| irq_en | input | 1 | Interrupt enable |
| dma_ack | input | 1 | Single-cycle DMA acknowledge |
| pop | input | 1 | Serializer takes the head pair |
| frame_valid | output | 1 | Head pair may be popped |
| head_left | output | 16 | Oldest left sample |
| head_right | output | 16 | Oldest right sample |
| full | output | 1 | Queue holds 4 pairs |
| empty | output | 1 | Queue holds no pairs |
| level | output | 3 | Number of stored pairs |
| irq | output | 1 | One-slot-free interrupt pulse |
| dma_req | output | 1 | One-slot-free DMA request |

## Verification
A wrong pointer or count shows up at the ports within one cycle: `level`, `full` and `empty` disagree with the number of accepted writes and pops, or the head samples leave out of order on the next pop. A wrong run/idle bit is visible the cycle after the queue drains or fills, through `frame_valid`. A lost staged sample or a wrong overwrite slot stays hidden until that pair reaches the head, at most four pops later. For this reason the bench drains the queue often and compares every head value against its own queue model.

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int SW = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [1:0]    wr_size,
  input  logic [2*SW-1:0] wr_data,
  input  logic          irq_en,
  input  logic          dma_ack,
  input  logic          pop,
  output logic          frame_valid,
  output logic [SW-1:0] head_left,
  output logic [SW-1:0] head_right,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level,
  output logic          irq,
  output logic          dma_req
);

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [LW-1:0] CAP  = LW'(DEPTH);

  logic [SW-1:0] mem_l [DEPTH];
  logic [SW-1:0] mem_r [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          running;
  logic          stg_v;
  logic [SW-1:0] stg_l;
  logic          irq_q, dreq_q;

  wire is_word  = wr_en && wr_size == SZ_WORD && !wr_hi;
  wire is_lhalf = wr_en && wr_size == SZ_HALF && !wr_hi;
  wire is_rhalf = wr_en && wr_size == SZ_HALF && wr_hi && stg_v;
  wire push     = is_word || is_rhalf;

  wire [SW-1:0] push_l = is_word ? wr_data[SW-1:0] : stg_l;
  wire [SW-1:0] push_r = is_word ? wr_data[2*SW-1:SW] : wr_data[SW-1:0];

  assign full        = (cnt == CAP);
  assign empty       = (cnt == '0);
  assign level       = cnt;
  assign frame_valid = running && !empty;
  assign head_left   = mem_l[rptr];
  assign head_right  = mem_r[rptr];
  assign irq         = irq_q;
  assign dma_req     = dreq_q;

  wire pop_fire  = pop && frame_valid;
  wire overwrite = push && full && !pop_fire;
  wire append    = push && !overwrite;

  wire [PW-1:0] newest = (wptr == '0) ? LAST : wptr - 1'b1;
  wire [PW-1:0] slot   = overwrite ? newest : wptr;
  wire [LW-1:0] cnt_nx = cnt + LW'(append) - LW'(pop_fire);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem_l[slot] <= push_l;
      mem_r[slot] <= push_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      if (append)   wptr <= bump(wptr);
      if (pop_fire) rptr <= bump(rptr);
      cnt <= cnt_nx;
      if (running && cnt_nx == '0)      running <= 1'b0;
      else if (!running && cnt_nx == CAP) running <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= 1'b0;
      stg_l <= '0;
    end else if (is_lhalf) begin
      stg_v <= 1'b1;
      stg_l <= wr_data[SW-1:0];
    end else if (is_rhalf) begin
      stg_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      dreq_q <= 1'b0;
    end else begin
      irq_q <= pop_fire && irq_en;
      if (pop_fire)     dreq_q <= 1'b1;
      else if (dma_ack) dreq_q <= 1'b0;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CAP); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (push && full && !pop_fire) |=> full); // R5
  AST_BYTE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b00 && !pop_fire) |=> $stable(level) && $stable(stg_v)); // R4
  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (empty && push) |=> !empty); // R6
  AST_RUN_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(running) |-> full); // R7
  AST_DMA_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n) pop_fire |=> dma_req); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(irq_en)); // R9

endmodule

// File: tb/stereo_tx_fifo_bench.sv
`timescale 1ns/100ps
module stereo_tx_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_hi = 0, irq_en = 1, dma_ack = 0, pop = 0;
  logic [1:0] wr_size = 0;
  logic [31:0] wr_data = 0;
  logic frame_valid, full, empty, irq, dma_req;
  logic [15:0] head_left, head_right;
  logic [2:0] level;

  always #2.5 clk = ~clk;

  stereo_tx_fifo u_stereo_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_size(wr_size),
    .wr_data(wr_data), .irq_en(irq_en), .dma_ack(dma_ack), .pop(pop),
    .frame_valid(frame_valid), .head_left(head_left), .head_right(head_right),
    .full(full), .empty(empty), .level(level), .irq(irq), .dma_req(dma_req));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] ql [4];
  logic [15:0] qr [4];
  int mc;
  bit mrun, msv, mdr, mirq;
  logic [15:0] msl;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mc = 0; mrun = 0; msv = 0; mdr = 0; mirq = 0; msl = 0;
  endtask

  task automatic model_step();
    bit pf, push;
    logic [15:0] pl, pr;
    pf = pop && mrun && mc > 0;
    push = 0; pl = 0; pr = 0;
    if (wr_en && wr_size == 2'b10 && !wr_hi) begin
      push = 1; pl = wr_data[15:0]; pr = wr_data[31:16];
    end else if (wr_en && wr_size == 2'b01 && !wr_hi) begin
      msv = 1; msl = wr_data[15:0];
    end else if (wr_en && wr_size == 2'b01 && wr_hi && msv) begin
      push = 1; pl = msl; pr = wr_data[15:0]; msv = 0;
    end
    if (pf) begin
      for (int i = 0; i < 3; i++) begin ql[i] = ql[i+1]; qr[i] = qr[i+1]; end
      mc--;
    end
    if (push) begin
      if (mc < 4) begin ql[mc] = pl; qr[mc] = pr; mc++; end
      else begin ql[3] = pl; qr[3] = pr; end
    end
    if (mrun && mc == 0) mrun = 0;
    else if (!mrun && mc == 4) mrun = 1;
    mirq = pf && irq_en;
    if (pf) mdr = 1; else if (dma_ack) mdr = 0;
  endtask

  task automatic compare();
    chk("R1 level", level, mc);
    chk("R1 full", full, mc == 4);
    chk("R6 empty", empty, mc == 0);
    chk("R7 frame_valid", frame_valid, mrun && mc > 0);
    if (mrun && mc > 0) begin
      chk("R2 R3 R12 head_left", head_left, ql[0]);
      chk("R2 R3 R12 head_right", head_right, qr[0]);
    end
    chk("R9 irq", irq, mirq);
    chk("R8 dma_req", dma_req, mdr);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr_en = 0; pop = 0; dma_ack = 0;
  endtask

  task automatic wr(input logic hi, input logic [1:0] sz, input logic [31:0] d);
    wr_en = 1; wr_hi = hi; wr_size = sz; wr_data = d; tick();
  endtask

  task automatic popn(int n);
    for (int i = 0; i < n; i++) begin pop = 1; tick(); end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 level", level, 0);
    chk("R11 empty", empty, 1);
    chk("R11 full", full, 0);
    chk("R11 frame_valid", frame_valid, 0);
    chk("R11 irq", irq, 0);
    chk("R11 dma_req", dma_req, 0);

    // R7: three pairs and pops stay idle
    wr(0, 2'b10, 32'h1111_0001);
    wr(0, 2'b10, 32'h2222_0002);
    wr(0, 2'b10, 32'h3333_0003);
    popn(2);
    chk("R7 idle below full", level, 3);
    wr(0, 2'b10, 32'h4444_0004);
    chk("R7 run at full", frame_valid, 1);
    // R5 overwrite newest
    wr(0, 2'b10, 32'h5555_0005);
    chk("R5 level stays", level, 4);
    // R4 byte, reserved and word-at-hi ignored
    wr(0, 2'b00, 32'hFFFF_FFFF);
    wr(1, 2'b11, 32'hFFFF_FFFF);
    wr(1, 2'b10, 32'hFFFF_FFFF);
    chk("R4 level unchanged", level, 4);
    popn(3);
    chk("R5 newest replaced", head_left, 16'h0005);
    chk("R5 newest replaced right", head_right, 16'h5555);
    popn(1);
    chk("R6 empty after drain", empty, 1);
    chk("R7 idle after drain", frame_valid, 0);
    // R3 R10 half pairs, left replaced, orphan right ignored
    wr(1, 2'b01, 32'h0000_DEAD);
    chk("R3 orphan right", level, 0);
    wr(0, 2'b01, 32'h0000_AAAA);
    wr(0, 2'b01, 32'h0000_BBBB);
    chk("R3 left alone", level, 0);
    wr(0, 2'b00, 32'h0000_CCCC);
    wr(1, 2'b01, 32'h0000_1234);
    for (int i = 0; i < 3; i++) wr(0, 2'b10, 32'h7000_0000 + i);
    chk("R10 staged left replaced", head_left, 16'hBBBB);
    chk("R3 right half", head_right, 16'h1234);
    irq_en = 0;
    popn(2);
    chk("R9 masked irq", irq, 0);
    chk("R8 dma with irq masked", dma_req, 1);
    dma_ack = 1; tick();
    chk("R8 ack clears", dma_req, 0);
    irq_en = 1;

    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 100;
      wr_hi = $urandom % 2;
      wr_data = $urandom;
      if (r < 35) begin wr_en = 1; wr_size = 2'b10; wr_hi = 0; end
      else if (r < 47) begin wr_en = 1; wr_size = 2'b01; wr_hi = 0; end
      else if (r < 59) begin wr_en = 1; wr_size = 2'b01; wr_hi = 1; end
      else if (r < 64) begin wr_en = 1; wr_size = 2'b00; end
      else if (r < 67) begin wr_en = 1; wr_size = 2'b11; end
      pop = ($urandom % 100) < 45;
      dma_ack = ($urandom % 4) == 0;
      if ($urandom % 50 == 0) irq_en = ~irq_en;
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule